// File: doc/BRIEF.md
# Time-Shared Stretched-Delay Allpass Cascade Filter

This block is a low-pass IIR filter built from four allpass-based sections in series. Each section is the same prototype, the mean of two first-order allpass branches, with every unit delay stretched by the factor k = 1, 2, 4 or 8 for sections 0 to 3. Stretching by k turns a response H(z) into H(z^k), so the section's magnitude response repeats k times between zero and the sample rate. When the four responses are multiplied, the repeated images cancel and a sharp low-pass response remains.

The four sections share one arithmetic pipeline. A slot counter rotates through the sections with period 4, so one section is computed in each clock cycle, and one sample can be accepted every four cycles. The recursive state of each section sits in shift-register delay lines in front of the shared pipeline. These lines advance once per processed sample. Small 4-way multiplexers choose which section's state and coefficients feed the pipeline in each cycle.

The control is a two-state machine. In IDLE the slot counter is held at 0 and `in_ready` is high. The transition IDLE→RUN is taken when a sample is accepted. In RUN the slot counter advances each cycle. The transition RUN→IDLE is taken at a slot wrap once no sample has been accepted for the full pipeline latency. Otherwise RUN→RUN.

Top module: `afc_cascade`

## Requirements
- R1: `in_ready` is high exactly when the slot counter is 0, which includes the whole of IDLE. A sample is taken on a rising clock edge where `in_valid` and `in_ready` are both high.
- R2: Each accepted sample produces exactly one output, in acceptance order. `out_valid` is high for a single cycle, 18 clock edges after the accepting edge.
- R3: Section s (s = 0..3) uses stretch k = 2^s. Its input is the section s-1 output, and the filter input for s = 0. With x its input, u[n] = x[n-k], and the rounded, saturating operators of R4:
  - ya[n] = ca·(x[n] − ya[n−2k]) + x[n−2k]
  - yb[n] = cb·(u[n] − yb[n−2k]) + u[n−2k]
- R4: Samples are 16-bit two's complement. Coefficients are 16-bit signed with 14 fraction bits. Section s takes `coef_a[16s+15:16s]` as ca and `coef_b[16s+15:16s]` as cb. A product is computed as (c·d + 8192) shifted right arithmetically by 14 and then clamped to [−32768, 32767]. Every difference and every sum is clamped to the same range.
- R5: The section output is (ya + yb + 1) shifted right arithmetically by 1, which rounds the mean half-up. `out_data` is the output of section 3.
- R6: A synchronous reset clears every delay line and every pipeline register. After reset, `out_valid` and `out_data` are 0, and later outputs match a filter that started from all-zero state.
- R7: When samples are offered continuously, one sample is accepted every 4 cycles. After each accept, `in_ready` is low for exactly 3 cycles.
- R8: `in_valid` and `in_data` have no effect while `in_ready` is low. The output stream is the same as when they are held idle.
- R9: After the last accepted sample has drained, the block returns to IDLE and `in_ready` stays high.
- R10: With all coefficients zero, each section outputs the rounded mean of its input delayed 2k and 3k samples. An impulse of 16384 therefore gives zero for outputs 0..29 and 1024 at output 30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 16 | Signed input sample |
| coef_a | input | 64 | Branch-a coefficient per section, Q1.14, section s at bits 16s+15:16s |
| coef_b | input | 64 | Branch-b coefficient per section, Q1.14, section s at bits 16s+15:16s |
| out_valid | output | 1 | One-cycle pulse marking a new output sample |
| out_data | output | 16 | Signed filter output, held between pulses |

## Verification
A fault in the slot rotation, a delay line or a multiplexer select mixes one section's state into another's computation. This shows at `out_data` as a mismatch against the sample-at-a-time model within a few outputs of the disturbance. A wrong stretch factor moves the first non-zero impulse output away from output 30. A timing fault in the scheduler or the drain counter shows within one frame: an out_valid pulse off the 18-cycle latency, an accept gap other than 3 cycles, or `in_ready` dropping while idle.

// File: rtl/afc_pkg.sv
package afc_pkg;
    localparam int DATA_W = 16;
    localparam int COEF_W = 16;
    localparam int FRAC_W = 14;
    localparam int WIDE_W = DATA_W + COEF_W + 2;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    localparam wide_t S_MAX = (wide_t'(1) <<< (DATA_W - 1)) - wide_t'(1);
    localparam wide_t S_MIN = -(wide_t'(1) <<< (DATA_W - 1));

    // Clamp a wide intermediate to the sample range.
    function automatic sample_t clamp(input wide_t v);
        if (v > S_MAX)
            return sample_t'(S_MAX);
        else if (v < S_MIN)
            return sample_t'(S_MIN);
        else
            return sample_t'(v);
    endfunction

    function automatic sample_t add_sat(input sample_t a, input sample_t b, input logic sub);
        wide_t s;
        s = sub ? (wide_t'(a) - wide_t'(b)) : (wide_t'(a) + wide_t'(b));
        return clamp(s);
    endfunction

    // Coefficient times sample, rounded to nearest, then clamped.
    function automatic sample_t mul_rnd(input coef_t c, input sample_t d);
        wide_t p;
        p = wide_t'(c) * wide_t'(d) + (wide_t'(1) <<< (FRAC_W - 1));
        return clamp(p >>> FRAC_W);
    endfunction

    // Half of a sum, rounded half-up; always fits the sample range.
    function automatic sample_t half_rnd(input sample_t a, input sample_t b);
        wide_t s;
        s = wide_t'(a) + wide_t'(b) + wide_t'(1);
        return sample_t'(s >>> 1);
    endfunction
endpackage

// File: rtl/afc_delay.sv
module afc_delay
    import afc_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  sample_t din,
    output sample_t dout
);
    sample_t stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                stage_q[i] <= '0;
        end else if (push) begin
            stage_q[0] <= din;
            for (int i = 1; i < DEPTH; i++)
                stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/afc_sched.sv
module afc_sched #(
    parameter int NSTAGE = 4,
    parameter int LAT    = 18,
    parameter int SLOT_W = $clog2(NSTAGE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              accept,
    output logic [SLOT_W-1:0] slot
);
    localparam int                CNT_W = $clog2(LAT + 1);
    localparam logic [SLOT_W-1:0] LAST  = SLOT_W'(NSTAGE - 1);

    typedef enum logic {ST_IDLE, ST_RUN} state_t;

    state_t            state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [CNT_W-1:0]  drain_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RUN;
            ST_RUN:  if (slot_q == LAST && drain_q == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // slot rotation and drain counter
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= '0;
            drain_q <= '0;
        end else begin
            if (state_q == ST_IDLE && !accept)
                slot_q <= '0;
            else if (slot_q == LAST)
                slot_q <= '0;
            else
                slot_q <= slot_q + 1'b1;

            if (accept)
                drain_q <= CNT_W'(LAT);
            else if (drain_q != '0)
                drain_q <= drain_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        in_ready = (slot_q == '0);
        accept   = in_valid && in_ready;
        slot     = slot_q;
    end

    assert_gap_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);

    assert_idle_holds_slot_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (slot_q == '0));
endmodule

// File: rtl/afc_core.sv
module afc_core
    import afc_pkg::*;
#(
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_v,
    input  logic [SLOT_W-1:0] iss_stg,
    input  sample_t           iss_x,
    input  sample_t           iss_xb,
    input  sample_t           iss_xa_d,
    input  sample_t           iss_xb_d,
    input  sample_t           iss_ya_d,
    input  sample_t           iss_yb_d,
    input  coef_t             iss_ca,
    input  coef_t             iss_cb,
    output logic              push_v,
    output logic [SLOT_W-1:0] push_stg,
    output sample_t           push_x,
    output sample_t           push_ya,
    output sample_t           push_yb,
    output logic              res_v,
    output logic [SLOT_W-1:0] res_stg,
    output sample_t           res
);
    // step 1: differences
    logic              v1;
    logic [SLOT_W-1:0] stg1;
    sample_t           x1, xad1, xbd1, da1, db1;
    coef_t             ca1, cb1;
    // step 2: products
    logic              v2;
    logic [SLOT_W-1:0] stg2;
    sample_t           x2, xad2, xbd2, pa2, pb2;
    // step 3: branch outputs
    logic              v3;
    logic [SLOT_W-1:0] stg3;
    sample_t           ya3, yb3;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0; stg1 <= '0; x1 <= '0; xad1 <= '0; xbd1 <= '0;
            da1 <= '0; db1 <= '0; ca1 <= '0; cb1 <= '0;
            v2 <= 1'b0; stg2 <= '0; x2 <= '0; xad2 <= '0; xbd2 <= '0;
            pa2 <= '0; pb2 <= '0;
            v3 <= 1'b0; stg3 <= '0; ya3 <= '0; yb3 <= '0;
        end else begin
            v1   <= iss_v;
            stg1 <= iss_stg;
            x1   <= iss_x;
            xad1 <= iss_xa_d;
            xbd1 <= iss_xb_d;
            da1  <= add_sat(iss_x, iss_ya_d, 1'b1);
            db1  <= add_sat(iss_xb, iss_yb_d, 1'b1);
            ca1  <= iss_ca;
            cb1  <= iss_cb;

            v2   <= v1;
            stg2 <= stg1;
            x2   <= x1;
            xad2 <= xad1;
            xbd2 <= xbd1;
            pa2  <= mul_rnd(ca1, da1);
            pb2  <= mul_rnd(cb1, db1);

            v3   <= v2;
            stg3 <= stg2;
            ya3  <= push_ya;
            yb3  <= push_yb;
        end
    end

    always_comb begin
        push_v   = v2;
        push_stg = stg2;
        push_x   = x2;
        push_ya  = add_sat(pa2, xad2, 1'b0);
        push_yb  = add_sat(pb2, xbd2, 1'b0);
        res_v    = v3;
        res_stg  = stg3;
        res      = half_rnd(ya3, yb3);
    end
endmodule

// File: rtl/afc_cascade.sv
module afc_cascade
    import afc_pkg::*;
#(
    parameter int NSTAGE = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic signed [DATA_W-1:0]   in_data,
    input  logic [NSTAGE*COEF_W-1:0]   coef_a,
    input  logic [NSTAGE*COEF_W-1:0]   coef_b,
    output logic                       out_valid,
    output logic signed [DATA_W-1:0]   out_data
);
    localparam int                SLOT_W = $clog2(NSTAGE);
    localparam int                LAT    = 3 + (NSTAGE - 1) * (NSTAGE + 1);
    localparam logic [SLOT_W-1:0] LAST   = SLOT_W'(NSTAGE - 1);

    logic              accept;
    logic [SLOT_W-1:0] slot, prev;

    sample_t tap_xb   [NSTAGE];
    sample_t tap_xa_d [NSTAGE];
    sample_t tap_xb_d [NSTAGE];
    sample_t tap_ya_d [NSTAGE];
    sample_t tap_yb_d [NSTAGE];

    sample_t hand   [NSTAGE];
    logic    hand_v [NSTAGE-1];

    logic              sel_v;
    sample_t           sel_x;
    coef_t             sel_ca, sel_cb;
    logic              push_v, res_v;
    logic [SLOT_W-1:0] push_stg, res_stg;
    sample_t           push_x, push_ya, push_yb, res;

    afc_sched #(.NSTAGE(NSTAGE), .LAT(LAT), .SLOT_W(SLOT_W)) u_sched (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_ready(in_ready), .accept(accept), .slot(slot)
    );

    // per-section stretched delay lines, advanced once per processed sample
    for (genvar s = 0; s < NSTAGE; s++) begin : g_sec
        localparam int K = 1 << s;
        logic push_s;
        assign push_s = push_v && (push_stg == SLOT_W'(s));

        afc_delay #(.DEPTH(K)) u_x1 (
            .clk(clk), .rst(rst), .push(push_s), .din(push_x), .dout(tap_xb[s]));
        afc_delay #(.DEPTH(K)) u_x2 (
            .clk(clk), .rst(rst), .push(push_s), .din(tap_xb[s]), .dout(tap_xa_d[s]));
        afc_delay #(.DEPTH(K)) u_x3 (
            .clk(clk), .rst(rst), .push(push_s), .din(tap_xa_d[s]), .dout(tap_xb_d[s]));
        afc_delay #(.DEPTH(2*K)) u_ya (
            .clk(clk), .rst(rst), .push(push_s), .din(push_ya), .dout(tap_ya_d[s]));
        afc_delay #(.DEPTH(2*K)) u_yb (
            .clk(clk), .rst(rst), .push(push_s), .din(push_yb), .dout(tap_yb_d[s]));
    end

    // section select for the current slot
    always_comb begin
        prev   = slot - 1'b1;
        sel_ca = coef_a[slot*COEF_W +: COEF_W];
        sel_cb = coef_b[slot*COEF_W +: COEF_W];
        if (slot == '0) begin
            sel_x = in_data;
            sel_v = accept;
        end else begin
            sel_x = hand[prev];
            sel_v = hand_v[prev];
        end
    end

    afc_core #(.SLOT_W(SLOT_W)) u_core (
        .clk(clk), .rst(rst),
        .iss_v(sel_v), .iss_stg(slot), .iss_x(sel_x),
        .iss_xb(tap_xb[slot]), .iss_xa_d(tap_xa_d[slot]), .iss_xb_d(tap_xb_d[slot]),
        .iss_ya_d(tap_ya_d[slot]), .iss_yb_d(tap_yb_d[slot]),
        .iss_ca(sel_ca), .iss_cb(sel_cb),
        .push_v(push_v), .push_stg(push_stg), .push_x(push_x),
        .push_ya(push_ya), .push_yb(push_yb),
        .res_v(res_v), .res_stg(res_stg), .res(res)
    );

    // hand-off registers between sections; the last one is the output
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            for (int s = 0; s < NSTAGE; s++)
                hand[s] <= '0;
            for (int s = 0; s < NSTAGE - 1; s++)
                hand_v[s] <= 1'b0;
        end else begin
            out_valid <= res_v && (res_stg == LAST);
            for (int s = 0; s < NSTAGE; s++)
                if (res_v && res_stg == SLOT_W'(s))
                    hand[s] <= res;
            for (int s = 0; s < NSTAGE - 1; s++)
                if (res_stg == SLOT_W'(s))
                    hand_v[s] <= res_v;
        end
    end

    assign out_data = hand[NSTAGE-1];

    assert_out_single_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_push_matches_slot_R3: assert property (@(posedge clk) disable iff (rst)
        push_v |-> (push_stg == $past(slot, 2)));
endmodule

// File: tb/test_afc_cascade.sv
module test_afc_cascade;
    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic signed [15:0]  in_data = '0;
    logic [63:0]         coef_a = '0;
    logic [63:0]         coef_b = '0;
    logic                out_valid;
    logic signed [15:0]  out_data;

    afc_cascade i_afc_cascade (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .coef_a(coef_a), .coef_b(coef_b),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #4 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    done = 0;
    string cur_req = "R3";
    int    exp_q[$];
    int    time_q[$];
    int    got[256];
    int    ocnt = 0;
    int    ca[4];
    int    cb[4];
    int    hx[4][256];
    int    hya[4][256];
    int    hyb[4][256];
    int    mn = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int bsat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int bmul(input int c, input int d);
        longint p;
        p = longint'(c) * longint'(d) + 64'sd8192;
        return bsat(p >>> 14);
    endfunction

    function automatic int gx(input int s, input int m);
        return (m < 0) ? 0 : hx[s][m];
    endfunction
    function automatic int gya(input int s, input int m);
        return (m < 0) ? 0 : hya[s][m];
    endfunction
    function automatic int gyb(input int s, input int m);
        return (m < 0) ? 0 : hyb[s][m];
    endfunction

    // Sample-at-a-time model of the four sections (R3, R4, R5)
    function automatic int model_step(input int x0);
        int x, n, k, ya, yb, u;
        x = x0;
        n = mn;
        for (int s = 0; s < 4; s++) begin
            k = 1 << s;
            hx[s][n] = x;
            ya = bsat(longint'(bmul(ca[s], bsat(longint'(x - gya(s, n - 2*k))))) + gx(s, n - 2*k));
            u  = gx(s, n - k);
            yb = bsat(longint'(bmul(cb[s], bsat(longint'(u - gyb(s, n - 2*k))))) + gx(s, n - 3*k));
            hya[s][n] = ya;
            hyb[s][n] = yb;
            x = (ya + yb + 1) >>> 1;
        end
        mn++;
        return x;
    endfunction

    task automatic set_coefs();
        for (int s = 0; s < 4; s++) begin
            coef_a[s*16 +: 16] = 16'(ca[s]);
            coef_b[s*16 +: 16] = 16'(cb[s]);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        exp_q.delete();
        time_q.delete();
        ocnt = 0;
        mn = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input int x, input bit noisy, input bit gapchk);
        int waits = 0;
        while (!in_ready) begin
            if (noisy) begin
                in_valid = 1'b1;
                in_data  = 16'($urandom);
            end
            @(negedge clk);
            waits++;
        end
        if (gapchk) check(waits == 3, "R7", waits, 3);
        in_valid = 1'b1;
        in_data  = 16'(x);
        exp_q.push_back(model_step(x));
        time_q.push_back(cyc);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input int n);
        repeat (n) @(negedge clk);
    endtask

    // output monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", int'(out_data), 0);
            end else begin
                int e, t;
                e = exp_q.pop_front();
                t = time_q.pop_front();
                check(int'(out_data) == e, cur_req, int'(out_data), e);
                check(cyc == t + 19, "R2", cyc - t, 19);
            end
            if (ocnt < 256) got[ocnt] = int'(out_data);
            ocnt++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            check(1'b0, "watchdog", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int zbad;
        for (int s = 0; s < 4; s++) begin ca[s] = 0; cb[s] = 0; end
        set_coefs();
        do_reset();
        // R6, R1: reset state
        check(out_valid == 1'b0, "R6", int'(out_valid), 0);
        check(out_data == 16'sd0, "R6", int'(out_data), 0);
        check(in_ready == 1'b1, "R1", int'(in_ready), 1);

        // R10: zero coefficients, impulse of 16384
        for (int i = 0; i < 48; i++) send((i == 0) ? 16384 : 0, 1'b0, i > 0);
        drain(40);
        zbad = 0;
        for (int i = 0; i < 30; i++) if (got[i] != 0) zbad++;
        check(zbad == 0, "R10", zbad, 0);
        check(got[30] == 1024, "R10", got[30], 1024);

        // R5: half-up rounding of the branch mean, impulse of 1
        do_reset();
        for (int i = 0; i < 40; i++) send((i == 0) ? 1 : 0, 1'b0, i > 0);
        drain(40);
        check(got[30] == 1, "R5", got[30], 1);

        // R3: impulse response with mixed coefficients
        do_reset();
        ca = '{8192, 6000, -4000, 3000};
        cb = '{-4915, 2000, 7000, -9000};
        set_coefs();
        for (int i = 0; i < 60; i++) send((i == 0) ? 12000 : 0, 1'b0, i > 0);
        drain(40);

        // R6: reset with samples in flight, then R8 noisy random stream
        ca = '{14746, -12000, 9830, 13000};
        cb = '{9830, 11000, -14000, 15000};
        set_coefs();
        for (int i = 0; i < 6; i++) send(int'($urandom_range(0, 20000)) - 10000, 1'b0, 1'b0);
        do_reset();
        check(out_valid == 1'b0, "R6", int'(out_valid), 0);
        check(out_data == 16'sd0, "R6", int'(out_data), 0);
        cur_req = "R8";
        for (int i = 0; i < 100; i++) send(int'($urandom_range(0, 40000)) - 20000, 1'b1, i > 0);
        in_valid = 1'b0;
        drain(40);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);
        check(ocnt == 100, "R8", ocnt, 100);

        // R4: saturation with full-scale square wave
        do_reset();
        cur_req = "R4";
        ca = '{-15565, -15565, -15565, -15565};
        cb = '{15565, 15565, 15565, 15565};
        set_coefs();
        for (int i = 0; i < 64; i++) send(((i / 3) % 2 == 0) ? 32767 : -32768, 1'b0, i > 0);
        drain(40);
        cur_req = "R3";

        // R9: idle after drain
        for (int i = 0; i < 8; i++) begin
            check(in_ready == 1'b1, "R9", int'(in_ready), 1);
            @(negedge clk);
        end

        // R2: single sample from idle, all outputs delivered
        send(777, 1'b0, 1'b0);
        drain(30);
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule